// File: doc/BRIEF.md
# Latched Serial-to-Parallel Output Expander

This block turns a serial bit stream into a parallel word that changes only when asked to. It has a chain of `WIDTH` shift stages. Each rising edge of a shift strobe captures the serial input into the first stage and moves every other stage one place toward the last. A separate storage strobe copies all stages at once into a holding register, and that register drives the parallel outputs. The visible outputs therefore stay steady while a new word is shifted in. The last stage is also brought out as a cascade bit. Feeding it into the serial input of a second block, with both strobes shared, gives a `2*WIDTH` chain.

Both strobes are plain levels, sampled in the system clock domain. Each strobe has its own two-state tracker. `STB_LOW` means the last sample was low and `STB_HIGH` means it was high. The *rise* transition (`STB_LOW` to `STB_HIGH`) sends a one-cycle pulse to the logic it serves. The *fall* transition (`STB_HIGH` to `STB_LOW`) sends nothing. Staying in either state sends nothing.

An active-low clear empties the shift stages and leaves the held outputs alone. A synchronous reset clears everything, including both trackers.

Top module: `expander_top`

## Requirements
- R1: On a clock edge where `shift_strobe` is high and was low at the previous edge, stage 0 takes `ser_in` and each stage i (i ≥ 1) takes the old value of stage i-1.
- R2: After N shift edges, the first bit presented sits in stage N-1 and the latest bit sits in stage 0. A `1011` input into a 4-stage chain reads last-to-first as 1,0,1,1.
- R3: `par_out` changes only at a clock edge where `store_strobe` rises, or during reset. Shifting and clearing leave it unchanged.
- R4: At a rising edge of `store_strobe`, all stages are copied at once: `par_out[i]` = stage i. The copy is visible after that clock edge and holds until the next storage rise.
- R5: `cascade_out` equals the last stage. Two blocks chained this way form a `2*WIDTH` register: after `2*WIDTH` shifts and one store, `{par_out_second, par_out_first}` equals the shifted word, first bit at the top.
- R6: While `clr_n` is low, every stage is zero after the next clock edge. Clear has priority over a shift, and `par_out` keeps its value.
- R7: While `rst` is high, at each clock edge `par_out`, the stages and both strobe trackers go to zero/`STB_LOW`.
- R8: If both strobes rise at the same edge, the stored word is the stage contents from before that shift.
- R9: A strobe held high for many cycles acts once. No further shift or store happens until it has fallen and risen again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| clr_n | input | 1 | Active-low clear of the shift stages |
| ser_in | input | 1 | Serial data input |
| shift_strobe | input | 1 | Shift strobe level; acts on its rising edge |
| store_strobe | input | 1 | Storage strobe level; acts on its rising edge |
| par_out | output | WIDTH | Held parallel word |
| cascade_out | output | 1 | Last shift stage, for chaining |

## Verification
The hardest case to reach from the ports is both strobes rising in the same sampled cycle (R8). The bench gets there by raising both levels in one drive step, after a full chained word has been loaded. It then checks that the held word is the pre-shift word, not the shifted one. A strobe held high for several cycles (R9) and a clear issued between a load and a store (R6) are also forced deliberately. Every cycle, a behavioural model of the 16-bit chain is compared with both blocks' outputs.

// File: rtl/expander_pkg.sv
package expander_pkg;

    typedef enum logic {
        STB_LOW  = 1'b0,
        STB_HIGH = 1'b1
    } stb_state_t;

endpackage

// File: rtl/strobe_edge.sv
module strobe_edge
    import expander_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic rise
);

    stb_state_t state_q;
    stb_state_t state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= STB_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        rise    = 1'b0;
        unique case (state_q)
            STB_LOW: begin
                if (level) begin
                    state_d = STB_HIGH;
                    rise    = 1'b1;
                end
            end
            STB_HIGH: begin
                if (!level) begin
                    state_d = STB_LOW;
                end
            end
            default: begin
                state_d = STB_LOW;
            end
        endcase
    end

    AST_SINGLE_RISE: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise); // R9

endmodule

// File: rtl/shift_chain.sv
module shift_chain #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_n,
    input  logic             shift_en,
    input  logic             ser_in,
    output logic [WIDTH-1:0] stages
);

    localparam int LAST = WIDTH - 1;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_stage
            logic next_bit;
            if (i == 0) begin : g_head
                assign next_bit = ser_in;
            end else begin : g_body
                assign next_bit = stages[i-1];
            end

            always_ff @(posedge clk) begin
                if (rst || !clr_n) begin
                    stages[i] <= 1'b0;
                end else if (shift_en) begin
                    stages[i] <= next_bit;
                end
            end
        end
    endgenerate

    AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (rst)
        !clr_n |=> (stages == '0)); // R6

    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (rst)
        (shift_en && clr_n) |=> (stages[0] == $past(ser_in))
                                && (stages[LAST:1] == $past(stages[LAST-1:0]))); // R1

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!shift_en && clr_n) |=> $stable(stages)); // R9

endmodule

// File: rtl/hold_reg.sv
module hold_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q)); // R3

    AST_STORE_COPY: assert property (@(posedge clk) disable iff (rst)
        load |=> (q == $past(d))); // R4

endmodule

// File: rtl/expander_top.sv
module expander_top #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_n,
    input  logic             ser_in,
    input  logic             shift_strobe,
    input  logic             store_strobe,
    output logic [WIDTH-1:0] par_out,
    output logic             cascade_out
);

    localparam int LAST = WIDTH - 1;

    logic             shift_rise;
    logic             store_rise;
    logic [WIDTH-1:0] stages;

    strobe_edge u_shift_edge (
        .clk   (clk),
        .rst   (rst),
        .level (shift_strobe),
        .rise  (shift_rise)
    );

    strobe_edge u_store_edge (
        .clk   (clk),
        .rst   (rst),
        .level (store_strobe),
        .rise  (store_rise)
    );

    shift_chain #(.WIDTH(WIDTH)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .clr_n    (clr_n),
        .shift_en (shift_rise),
        .ser_in   (ser_in),
        .stages   (stages)
    );

    hold_reg #(.WIDTH(WIDTH)) u_hold (
        .clk  (clk),
        .rst  (rst),
        .load (store_rise),
        .d    (stages),
        .q    (par_out)
    );

    assign cascade_out = stages[LAST];

    AST_BOTH_PRESHIFT: assert property (@(posedge clk) disable iff (rst)
        (shift_rise && store_rise) |=> (par_out == $past(stages))); // R8

    AST_CASCADE_ORDER: assert property (@(posedge clk) disable iff (rst)
        (shift_rise && clr_n) |=> (cascade_out == $past(stages[LAST-1]))); // R2

endmodule

// File: tb/test_expander_top.sv
module test_expander_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         clr_n = 1'b1;
    logic         ser = 1'b0;
    logic         shift_s = 1'b0;
    logic         store_s = 1'b0;
    logic [W-1:0] par_a;
    logic [W-1:0] par_b;
    logic         casc_a;
    logic         casc_b;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    // 50 MHz
    always #10 clk = ~clk;

    expander_top #(.WIDTH(W)) i_expander_top (
        .clk(clk), .rst(rst), .clr_n(clr_n), .ser_in(ser),
        .shift_strobe(shift_s), .store_strobe(store_s),
        .par_out(par_a), .cascade_out(casc_a)
    );

    expander_top #(.WIDTH(W)) i_expander_top_next (
        .clk(clk), .rst(rst), .clr_n(clr_n), .ser_in(casc_a),
        .shift_strobe(shift_s), .store_strobe(store_s),
        .par_out(par_b), .cascade_out(casc_b)
    );

    // behavioural model of the 16-bit chained register
    logic [15:0] m_chain = '0;
    logic [15:0] m_held = '0;
    logic        m_prev_shift = 1'b0;
    logic        m_prev_store = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            m_chain = '0;
            m_held = '0;
            m_prev_shift = 1'b0;
            m_prev_store = 1'b0;
        end else begin
            if (store_s && !m_prev_store) m_held = m_chain;
            if (!clr_n) m_chain = '0;
            else if (shift_s && !m_prev_shift) m_chain = {m_chain[14:0], ser};
            m_prev_shift = shift_s;
            m_prev_store = store_s;
        end
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R4 held word", {par_b, par_a}, m_held);
            check("R5 cascade", {14'd0, casc_b, casc_a}, {14'd0, m_chain[15], m_chain[7]});
        end
    end

    task automatic step();
        @(posedge clk);
        #3;
    endtask

    task automatic shift_bit(input logic b);
        step();
        ser = b;
        shift_s = 1'b1;
        step();
        shift_s = 1'b0;
    endtask

    task automatic store_word();
        step();
        store_s = 1'b1;
        step();
        store_s = 1'b0;
    endtask

    task automatic load_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) shift_bit(w[i]);
    endtask

    initial begin
        logic [15:0] pat;
        pat = 16'hA5C3;
        repeat (3) step();
        rst = 1'b0;
        @(negedge clk);
        check("R7 reset outputs", {par_b, par_a}, 16'h0000);
        check("R7 reset cascade", {15'd0, casc_b}, 16'h0000);

        // R2: 4 shifts of 1011 -> stages 3..0 = 1,0,1,1
        load_word(16'h000B);
        store_word();
        @(negedge clk);
        check("R2 order 1011", {8'h00, par_a}, 16'h000B);

        // R3: load a full chained word, outputs must not move
        load_word(pat);
        @(negedge clk);
        check("R3 outputs steady while shifting", {par_b, par_a}, 16'h000B);
        check("R5 cascade holds first bit", {15'd0, casc_b}, {15'd0, pat[15]});
        store_word();
        @(negedge clk);
        check("R5 chained 16-bit word", {par_b, par_a}, pat);
        check("R4 store copy", par_a, pat[7:0]);

        // R8: both strobes rise together
        step();
        ser = 1'b1;
        shift_s = 1'b1;
        store_s = 1'b1;
        step();
        shift_s = 1'b0;
        store_s = 1'b0;
        @(negedge clk);
        check("R8 pre-shift word stored", {par_b, par_a}, pat);
        store_word();
        @(negedge clk);
        check("R1 one shift after joint rise", {par_b, par_a}, {pat[14:0], 1'b1});

        // R9: strobe held high several cycles -> one shift
        step();
        ser = 1'b0;
        shift_s = 1'b1;
        repeat (5) step();
        shift_s = 1'b0;
        store_word();
        @(negedge clk);
        check("R9 held strobe shifts once", {par_b, par_a}, {pat[13:0], 1'b1, 1'b0});
        step();
        store_s = 1'b1;
        repeat (4) step();
        load_word(16'h3C3C);
        @(negedge clk);
        check("R9 held store acts once", {par_b, par_a}, {pat[13:0], 1'b1, 1'b0});
        store_s = 1'b0;
        store_word();
        @(negedge clk);
        check("R1 new word after re-arm", {par_b, par_a}, 16'h3C3C);

        // R6: clear empties stages, outputs kept, priority over shift
        step();
        clr_n = 1'b0;
        ser = 1'b1;
        shift_s = 1'b1;
        step();
        clr_n = 1'b1;
        shift_s = 1'b0;
        @(negedge clk);
        check("R6 outputs kept on clear", {par_b, par_a}, 16'h3C3C);
        check("R6 cascade cleared", {15'd0, casc_b}, 16'h0000);
        store_word();
        @(negedge clk);
        check("R6 stages empty after clear", {par_b, par_a}, 16'h0000);

        // R7: reset mid-stream
        load_word(16'hFFFF);
        store_word();
        step();
        rst = 1'b1;
        step();
        rst = 1'b0;
        @(negedge clk);
        check("R7 reset clears held word", {par_b, par_a}, 16'h0000);
        check("R7 reset clears cascade", {15'd0, casc_b}, 16'h0000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2_000_000;
        errors++;
        done = 1'b1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule